// File: doc/BRIEF.md
# Round-Robin Voice Interrupt Arbiter

This block gathers the interrupt flags raised by up to 32 synthesis voices. Every voice has two flags: one set when its sample address crosses a loop or end boundary (the wave flag) and one set when its volume ramp reaches its target (the ramp flag). The voices pulse set lines, and the arbiter holds the flags. Only voices below a programmable active count take part in arbitration. The arbiter drives two summary bits, one for ramp events and one for wave events, and a host interrupt line gated by an enable bit in a mix-control byte.

The host services voices one at a time through a status byte. That byte names the voice currently selected by a scan pointer and shows which of its two flags are pending, as active-low bits. A read strobe acknowledges that voice: both of its flags are cleared. In the same clock the pointer moves on to the next pending active voice, wrapping at the active count, so pending voices are served in rotation.

Top module: `voice_irq_arbiter`

## Requirements
- R1: A write with `cnt_wr` loads the active count as 1 plus the 6-bit `cnt_code`, clamped to the range 14..32. The count is visible on `active_cnt` one clock later. After reset the count is 14.
- R2: When no active voice has a pending flag, both summary bits are 0 and the scan pointer keeps its value. Reads in this state leave the pointer unchanged.
- R3: When some active voice has a pending flag, `pend_ramp` is 1 exactly when an active voice has a ramp flag, and `pend_wave` is 1 exactly when an active voice has a wave flag.
- R4: The pointer stays put while its own voice is active and pending. Otherwise it steps to pointer+1, wrapping to 0 whenever the next index would reach the active count, and stops at the first active pending voice.
- R5: `stat_byte` bits 4:0 hold the pointer voice number and bit 5 is always 1. Bit 6 is 1 when that voice has no ramp flag, and bit 7 is 1 when it has no wave flag.
- R6: A clock with `stat_rd` high clears both flags of the voice shown in `stat_byte`. The summary bits and the pointer are re-evaluated from the resulting flags in that same clock.
- R7: `host_irq` is 1 exactly when at least one summary bit is 1 and `mix_ctrl` bit 3 is 1.
- R8: A synchronous reset clears all flags and both summary bits, sets the pointer to voice 0 and sets the count to 14.
- R9: A set pulse for a voice in the same clock as the read that clears it wins: the flag stays pending.
- R10: Flags of voices at or above the active count are held but do not take part in arbitration. They take part again once the count is raised above them.

Top module ports are listed below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wave_set | input | 32 | Per-voice wave flag set pulses |
| ramp_set | input | 32 | Per-voice ramp flag set pulses |
| cnt_wr | input | 1 | Active count write strobe |
| cnt_code | input | 6 | Active count code (count minus one) |
| mix_ctrl | input | 8 | Mix-control byte; bit 3 enables the host interrupt |
| stat_rd | input | 1 | Status read and acknowledge strobe |
| stat_byte | output | 8 | Voice status byte for the pointer voice |
| pend_ramp | output | 1 | Summary: an active voice has a ramp flag |
| pend_wave | output | 1 | Summary: an active voice has a wave flag |
| host_irq | output | 1 | Host interrupt request |
| active_cnt | output | 7 | Current active voice count |

## Verification
The hardest situation to reach is a pointer that sits at or above a newly lowered active count while pending voices remain below it. The search must then wrap straight to voice 0 and not walk through inactive indices. The stimulus gets there in three steps: it raises the count to 32, parks the pointer on a high voice by flagging and reading it, and then rewrites the count to 14 with low voices pending. Set-versus-clear collisions on the reported voice are driven on purpose. A long pseudo-random run then mixes sets, reads and count writes against an arithmetic model.

// File: rtl/voice_irq_pkg.sv
package voice_irq_pkg;

    localparam int CODE_W    = 6;
    localparam int CNT_W     = CODE_W + 1;
    localparam int FIELD_W   = 5;
    localparam int STAT_MARK = 5;

    typedef struct packed {
        logic ramp;
        logic wave;
    } summ_t;

    function automatic logic [CNT_W-1:0] clamp_count(
        input logic [CODE_W-1:0] code,
        input int                lo,
        input int                hi
    );
        int c;
        c = int'(code) + 1;
        if (c < lo) c = lo;
        if (c > hi) c = hi;
        return CNT_W'(c);
    endfunction

    function automatic logic [7:0] pack_status(
        input logic [FIELD_W-1:0] voice,
        input logic               has_ramp,
        input logic               has_wave
    );
        logic [7:0] b;
        b                 = '0;
        b[FIELD_W-1:0]    = voice;
        b[STAT_MARK]      = 1'b1;
        b[6]              = ~has_ramp;
        b[7]              = ~has_wave;
        return b;
    endfunction

endpackage

// File: rtl/vi_count_reg.sv
module vi_count_reg
    import voice_irq_pkg::*;
#(
    parameter int NUM_VOICES = 32,
    parameter int MIN_ACTIVE = 14
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr,
    input  logic [CODE_W-1:0]     code,
    output logic [CNT_W-1:0]      cnt_q,
    output logic [CNT_W-1:0]      cnt_d,
    output logic [NUM_VOICES-1:0] mask_d
);

    always_comb begin
        cnt_d = cnt_q;
        if (wr) cnt_d = clamp_count(code, MIN_ACTIVE, NUM_VOICES);
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= CNT_W'(MIN_ACTIVE);
        else     cnt_q <= cnt_d;
    end

    for (genvar i = 0; i < NUM_VOICES; i++) begin : g_mask
        assign mask_d[i] = (cnt_d > CNT_W'(i));
    end

endmodule

// File: rtl/vi_flag_bank.sv
module vi_flag_bank #(
    parameter int NUM_VOICES = 32
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NUM_VOICES-1:0] set_in,
    input  logic [NUM_VOICES-1:0] clr_in,
    output logic [NUM_VOICES-1:0] flag_q,
    output logic [NUM_VOICES-1:0] flag_d
);

    for (genvar i = 0; i < NUM_VOICES; i++) begin : g_voice
        assign flag_d[i] = set_in[i] | (flag_q[i] & ~clr_in[i]);

        always_ff @(posedge clk) begin
            if (rst) flag_q[i] <= 1'b0;
            else     flag_q[i] <= flag_d[i];
        end
    end

endmodule

// File: rtl/vi_scan.sv
module vi_scan
    import voice_irq_pkg::*;
#(
    parameter int NUM_VOICES = 32,
    localparam int PTR_W     = $clog2(NUM_VOICES)
) (
    input  logic [PTR_W-1:0]      ptr,
    input  logic [NUM_VOICES-1:0] pend,
    input  logic [CNT_W-1:0]      cnt,
    output logic [PTR_W-1:0]      nxt,
    output logic                  found
);

    always_comb begin
        logic [PTR_W-1:0] c;
        c     = ptr;
        nxt   = ptr;
        found = pend[ptr];
        for (int k = 1; k <= NUM_VOICES; k++) begin
            if (int'(c) + 1 >= int'(cnt)) c = '0;
            else                          c = c + 1'b1;
            if (!found && pend[c]) begin
                found = 1'b1;
                nxt   = c;
            end
        end
    end

endmodule

// File: rtl/voice_irq_arbiter.sv
module voice_irq_arbiter
    import voice_irq_pkg::*;
#(
    parameter int NUM_VOICES = 32,
    parameter int MIN_ACTIVE = 14,
    localparam int PTR_W     = $clog2(NUM_VOICES)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NUM_VOICES-1:0] wave_set,
    input  logic [NUM_VOICES-1:0] ramp_set,
    input  logic                  cnt_wr,
    input  logic [CODE_W-1:0]     cnt_code,
    input  logic [7:0]            mix_ctrl,
    input  logic                  stat_rd,
    output logic [7:0]            stat_byte,
    output logic                  pend_ramp,
    output logic                  pend_wave,
    output logic                  host_irq,
    output logic [CNT_W-1:0]      active_cnt
);

    localparam int IRQ_EN_BIT = 3;

    logic [CNT_W-1:0]      cnt_d;
    logic [NUM_VOICES-1:0] mask_d;
    logic [NUM_VOICES-1:0] wave_q, wave_d, ramp_q, ramp_d;
    logic [NUM_VOICES-1:0] ack_vec;
    logic [NUM_VOICES-1:0] pend_act;
    logic [PTR_W-1:0]      ptr_q, ptr_nxt;
    logic                  hit;
    summ_t                 summ_q, summ_d;

    vi_count_reg #(.NUM_VOICES(NUM_VOICES), .MIN_ACTIVE(MIN_ACTIVE)) u_cnt (
        .clk(clk), .rst(rst), .wr(cnt_wr), .code(cnt_code),
        .cnt_q(active_cnt), .cnt_d(cnt_d), .mask_d(mask_d)
    );

    for (genvar i = 0; i < NUM_VOICES; i++) begin : g_ack
        assign ack_vec[i] = stat_rd && (ptr_q == PTR_W'(i));
    end

    vi_flag_bank #(.NUM_VOICES(NUM_VOICES)) u_wave (
        .clk(clk), .rst(rst), .set_in(wave_set), .clr_in(ack_vec),
        .flag_q(wave_q), .flag_d(wave_d)
    );

    vi_flag_bank #(.NUM_VOICES(NUM_VOICES)) u_ramp (
        .clk(clk), .rst(rst), .set_in(ramp_set), .clr_in(ack_vec),
        .flag_q(ramp_q), .flag_d(ramp_d)
    );

    assign pend_act = (wave_d | ramp_d) & mask_d;

    vi_scan #(.NUM_VOICES(NUM_VOICES)) u_scan (
        .ptr(ptr_q), .pend(pend_act), .cnt(cnt_d),
        .nxt(ptr_nxt), .found(hit)
    );

    always_comb begin
        summ_d = '0;
        if (|pend_act) begin
            summ_d.ramp = |(ramp_d & mask_d);
            summ_d.wave = |(wave_d & mask_d);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q  <= '0;
            summ_q <= '0;
        end else begin
            summ_q <= summ_d;
            if (hit) ptr_q <= ptr_nxt;
        end
    end

    assign stat_byte = pack_status(FIELD_W'(ptr_q), ramp_q[ptr_q], wave_q[ptr_q]);
    assign pend_ramp = summ_q.ramp;
    assign pend_wave = summ_q.wave;
    assign host_irq  = (summ_q.ramp | summ_q.wave) & mix_ctrl[IRQ_EN_BIT];

endmodule

// File: rtl/voice_irq_arbiter_chk.sv
module voice_irq_arbiter_chk
    import voice_irq_pkg::*;
#(
    parameter int NUM_VOICES = 32,
    parameter int MIN_ACTIVE = 14
) (
    input logic                  clk,
    input logic                  rst,
    input logic [NUM_VOICES-1:0] wave_set,
    input logic [NUM_VOICES-1:0] ramp_set,
    input logic                  cnt_wr,
    input logic [7:0]            mix_ctrl,
    input logic                  stat_rd,
    input logic [7:0]            stat_byte,
    input logic                  pend_ramp,
    input logic                  pend_wave,
    input logic                  host_irq,
    input logic [CNT_W-1:0]      active_cnt
);

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
        (active_cnt >= CNT_W'(MIN_ACTIVE)) && (active_cnt <= CNT_W'(NUM_VOICES))); // R1

    AST_IDLE_PTR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!pend_ramp && !pend_wave && wave_set == '0 && ramp_set == '0 && !cnt_wr)
        |=> $stable(stat_byte[FIELD_W-1:0])); // R2

    AST_WAVE_SUMMARY: assert property (@(posedge clk) disable iff (rst)
        (CNT_W'(stat_byte[FIELD_W-1:0]) < active_cnt && !stat_byte[7]) |-> pend_wave); // R3

    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
        host_irq |-> (mix_ctrl[3] && (pend_ramp || pend_wave))); // R7

    AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (stat_byte[FIELD_W-1:0] == '0 && !pend_ramp && !pend_wave)); // R8

    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        (stat_rd && !cnt_wr && wave_set[stat_byte[FIELD_W-1:0]]
         && CNT_W'(stat_byte[FIELD_W-1:0]) < active_cnt) |=> pend_wave); // R9

endmodule

bind voice_irq_arbiter voice_irq_arbiter_chk #(
    .NUM_VOICES(NUM_VOICES), .MIN_ACTIVE(MIN_ACTIVE)
) u_chk (
    .clk(clk), .rst(rst), .wave_set(wave_set), .ramp_set(ramp_set),
    .cnt_wr(cnt_wr), .mix_ctrl(mix_ctrl), .stat_rd(stat_rd),
    .stat_byte(stat_byte), .pend_ramp(pend_ramp), .pend_wave(pend_wave),
    .host_irq(host_irq), .active_cnt(active_cnt)
);

// File: tb/sim_voice_irq_arbiter.sv
`timescale 1ns/1ps
module sim_voice_irq_arbiter;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] wave_set = '0, ramp_set = '0;
    logic        cnt_wr = 1'b0;
    logic [5:0]  cnt_code = '0;
    logic [7:0]  mix_ctrl = 8'h08;
    logic        stat_rd = 1'b0;
    logic [7:0]  stat_byte;
    logic        pend_ramp, pend_wave, host_irq;
    logic [6:0]  active_cnt;

    int total = 0, bad = 0;
    bit done = 0;
    string ctx = "R8";

    logic [31:0] mw, mr;
    int mptr, mcnt;
    bit mrs, mws;

    always #5 clk = ~clk;

    voice_irq_arbiter u0 (
        .clk(clk), .rst(rst), .wave_set(wave_set), .ramp_set(ramp_set),
        .cnt_wr(cnt_wr), .cnt_code(cnt_code), .mix_ctrl(mix_ctrl),
        .stat_rd(stat_rd), .stat_byte(stat_byte), .pend_ramp(pend_ramp),
        .pend_wave(pend_wave), .host_irq(host_irq), .active_cnt(active_cnt)
    );

    task automatic check(input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", ctx, what, act, exp);
        end
    endtask

    task automatic compare_all();
        logic [7:0] eb;
        eb = {~mw[mptr], ~mr[mptr], 1'b1, 5'(mptr)};
        check("stat_byte (R4 R5)", int'(stat_byte), int'(eb));
        check("pend_ramp (R3)", int'(pend_ramp), int'(mrs));
        check("pend_wave (R3)", int'(pend_wave), int'(mws));
        check("host_irq (R7)", int'(host_irq), int'((mrs | mws) & mix_ctrl[3]));
        check("active_cnt (R1)", int'(active_cnt), mcnt);
    endtask

    function automatic void model_eval();
        logic [31:0] act, pend;
        int c;
        act = '0;
        for (int i = 0; i < 32; i++) act[i] = (i < mcnt);
        pend = (mw | mr) & act;
        if (pend == '0) begin
            mrs = 0; mws = 0;
        end else begin
            mrs = |(mr & act);
            mws = |(mw & act);
            if (!pend[mptr]) begin
                c = mptr;
                for (int k = 0; k < 32; k++) begin
                    c = (c + 1 >= mcnt) ? 0 : c + 1;
                    if (pend[c]) begin mptr = c; break; end
                end
            end
        end
    endfunction

    task automatic tick(input logic [31:0] ws, input logic [31:0] rs,
                        input bit rd, input bit cw, input logic [5:0] code);
        wave_set = ws; ramp_set = rs; stat_rd = rd; cnt_wr = cw; cnt_code = code;
        if (cw) begin
            mcnt = int'(code) + 1;
            if (mcnt < 14) mcnt = 14;
            if (mcnt > 32) mcnt = 32;
        end
        if (rd) begin mw[mptr] = 1'b0; mr[mptr] = 1'b0; end
        mw = mw | ws;
        mr = mr | rs;
        model_eval();
        @(posedge clk);
        @(negedge clk);
        wave_set = '0; ramp_set = '0; stat_rd = 0; cnt_wr = 0;
        compare_all();
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : stim
        logic [31:0] lf;
        mw = '0; mr = '0; mptr = 0; mcnt = 14; mrs = 0; mws = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        ctx = "R8";
        compare_all();

        ctx = "R1";
        for (int v = 0; v < 64; v++) tick('0, '0, 0, 1, 6'(v));

        ctx = "R10";
        tick('0, '0, 0, 1, 6'd5);
        tick(32'h1 << 20, '0, 0, 0, '0);
        ctx = "R2";
        tick('0, '0, 1, 0, '0);
        tick('0, '0, 1, 0, '0);
        ctx = "R10";
        tick('0, '0, 0, 1, 6'd31);

        ctx = "R6";
        tick(32'h0000_0110, 32'h8000_0004, 0, 0, '0);
        for (int n = 0; n < 6; n++) tick('0, '0, 1, 0, '0);

        ctx = "R9";
        tick(32'h0000_0200, 32'h0000_0200, 0, 0, '0);
        tick(32'h0000_0200, '0, 1, 0, '0);
        tick('0, 32'h0000_0200, 1, 0, '0);
        tick('0, '0, 1, 0, '0);

        ctx = "R7";
        tick('0, 32'h1 << 2, 0, 0, '0);
        mix_ctrl = 8'hF7; @(negedge clk); compare_all();
        mix_ctrl = 8'h08; @(negedge clk); compare_all();
        tick('0, '0, 1, 0, '0);

        ctx = "R4";
        tick(32'h1 << 28, '0, 0, 0, '0);
        tick(32'h0000_0009, '0, 0, 0, '0);
        tick('0, '0, 0, 1, 6'd0);
        for (int n = 0; n < 4; n++) tick('0, '0, 1, 0, '0);
        tick('0, '0, 0, 1, 6'd63);
        for (int n = 0; n < 3; n++) tick('0, '0, 1, 0, '0);

        ctx = "R3";
        lf = 32'hACE1_2468;
        for (int n = 0; n < 3000; n++) begin
            logic [31:0] a, b;
            lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
            a = lf & (lf >> 9) & (lf >> 3);
            b = lf & (lf << 7) & (lf >> 11);
            tick(a, b, lf[1] & lf[6], (lf[20:16] == 5'd3), 6'(lf[29:24]));
        end

        ctx = "R8";
        rst = 1;
        mw = '0; mr = '0; mptr = 0; mcnt = 14; mrs = 0; mws = 0;
        @(negedge clk); @(negedge clk);
        rst = 0;
        @(negedge clk);
        compare_all();

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule